// File: doc/BRIEF.md
# Synchronous SRAM Access Controller

This block sits between the registered control pins of a single-ported synchronous SRAM and its storage array. On every rising clock edge where the active-low clock enable is asserted, it samples three chip selects of mixed polarity, write enable, per-lane byte-write enables, an advance/load control and the address. The address comes from an external burst sequencer. Each qualified edge becomes one of three states for the following cycle: deselected, read data phase or write data phase.

A read command presents the stored word in the cycle after the command edge. A write command captures the incoming word on the next qualified edge. That write is masked per 9-bit lane, and each lane's parity bit is included in its mask. The data pins are split into an input word, an output word and one output-enable. The output-enable combines an asynchronous output-enable input, a sleep input and the internal state. The outputs are forced off during write data phases, during the first data phase after leaving the deselected state, and while the device is deselected.

Top module: `sram_access_ctrl`

## Requirements
- R1: A load edge (adv_ld low) selects the device only when ce1_n is 0, ce2 is 1 and ce3_n is 0. With any other combination, the next cycle is deselected: no write happens and dq_oe stays 0.
- R2: On a rising edge where cen_n is 1, every synchronous input is ignored. The pending operation, its address and the array contents are held, and the cycle is extended without deselecting the device.
- R3: we_n low on a selecting load edge starts a write. The word on dq_in at the next qualified edge is stored at the address given with the command. A read command never changes the array, whatever bw_n holds.
- R4: Lane i occupies dq bits [9i+8:9i], and bit 9i+8 is that lane's parity bit. During a write data phase, lane i (parity included) is stored only when bw_n[i] was 0 on the edge that opened that data phase. Other lanes keep their contents.
- R5: The word at the address of a read command appears on dq_out in the cycle after the command edge. dq_oe is 1 there only while oe_n is 0, and oe_n acts combinationally.
- R6: During a write data phase, dq_oe is 0 even when oe_n is 0.
- R7: The first data phase after a deselected cycle is never driven, so a read issued straight after deselect leaves the bus floating. A read that continues from a read is driven.
- R8: An advance edge (adv_ld high) repeats the previous operation type at the newly sampled address and ignores the chip selects and we_n. An advance edge taken while deselected leaves the device deselected.
- R9: A qualified edge with sleep high accepts no access and leaves the device deselected. dq_oe is 0 for as long as sleep is high, and stored contents are kept.
- R10: After reset the device is deselected and dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock qualifier |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | LANES | Per-lane byte-write enables, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-activity request, active high |
| addr | input | ADDR_W | Word address from the burst sequencer |
| dq_in | input | LANES*LANE_W | Data arriving at the pins |
| dq_out | output | LANES*LANE_W | Data presented to the pins |
| dq_oe | output | 1 | Pin driver enable for dq_out |

## Verification
The clocked assertions assume that every control input is settled before each rising edge and that reset is applied before the first command. The bench therefore changes inputs only at falling edges. The sleep and output-enable checks rely on those two inputs taking effect combinationally, so the bench samples dq_oe a short delay after toggling them. Reads in the bench target only addresses that were written earlier, so every compared word is fully defined.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/sram_cmd_seq.sv
module sram_cmd_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              adv_ld,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  bw_q,
  output logic              first_q,
  output logic              wr_commit
);

  logic              selected;
  op_e               op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  bw_d;
  logic              first_d;

  // next-state decode
  always_comb begin
    selected = !ce1_n && ce2 && !ce3_n;
    op_d     = op_q;
    addr_d   = addr_q;
    bw_d     = bw_q;
    first_d  = first_q;
    if (!cen_n) begin
      addr_d = addr;
      bw_d   = bw_n;
      if (sleep)          op_d = OP_IDLE;
      else if (adv_ld)    op_d = op_q;
      else if (!selected) op_d = OP_IDLE;
      else if (!we_n)     op_d = OP_WRITE;
      else                op_d = OP_READ;
      first_d = (op_q == OP_IDLE) && (op_d != OP_IDLE);
    end
  end

  // a write data phase commits on the next qualified edge
  assign wr_commit = !cen_n && (op_q == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      bw_q    <= '1;
      first_q <= 1'b0;
    end else begin
      op_q    <= op_d;
      addr_q  <= addr_d;
      bw_q    <= bw_d;
      first_q <= first_d;
    end
  end

  AST_CEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(op_q) && $stable(addr_q) && $stable(bw_q))); // R2
  AST_DESEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !sleep && (ce1_n || !ce2 || ce3_n)) |=> (op_q == OP_IDLE)); // R1
  AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && !sleep) |=> (op_q == $past(op_q))); // R8
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && sleep) |=> (op_q == OP_IDLE)); // R9

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask_n,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // one storage column per lane; the lane's parity bit lives in its top bit
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wr_mask_n[g]) begin
        mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[acc_addr];
  end

endmodule

// File: rtl/sram_bus_gate.sv
module sram_bus_gate
  import sram_ctrl_pkg::*;
(
  input  logic oe_n,
  input  logic sleep,
  input  op_e  op_q,
  input  logic first_q,
  output logic dq_oe
);

  logic read_phase;

  always_comb begin
    read_phase = (op_q == OP_READ) && !first_q;
    dq_oe      = read_phase && !oe_n && !sleep;
  end

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    adv_ld,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  bw_q;
  logic              first_q;
  logic              wr_commit;
  logic [DATA_W-1:0] rd_word;

  sram_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_n     (cen_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .we_n      (we_n),
    .bw_n      (bw_n),
    .adv_ld    (adv_ld),
    .sleep     (sleep),
    .addr      (addr),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .bw_q      (bw_q),
    .first_q   (first_q),
    .wr_commit (wr_commit)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk       (clk),
    .wr_en     (wr_commit),
    .wr_mask_n (bw_q),
    .acc_addr  (addr_q),
    .wdata     (dq_in),
    .rdata     (rd_word)
  );

  sram_bus_gate i_gate (
    .oe_n    (oe_n),
    .sleep   (sleep),
    .op_q    (op_q),
    .first_q (first_q),
    .dq_oe   (dq_oe)
  );

  assign dq_out = rd_word;

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> !dq_oe); // R6
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> !dq_oe); // R7
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe); // R9
  AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R5

endmodule

// File: tb/test_sram_access_ctrl.sv
module test_sram_access_ctrl;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cen_n, ce1_n, ce2, ce3_n, we_n, adv_ld, oe_n, sleep;
  logic [LANES-1:0]  bw_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     dq_in;
  logic [DW-1:0]     dq_out;
  logic              dq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_access_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_sram_access_ctrl (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .we_n(we_n), .bw_n(bw_n), .adv_ld(adv_ld), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load(input bit sel, input bit wr, input int a, input logic [1:0] bw);
    cen_n = 0; adv_ld = 0; ce1_n = !sel; ce2 = 1; ce3_n = 0;
    we_n = !wr; addr = ADDR_W'(a); bw_n = bw;
  endtask

  task automatic advance(input int a, input logic [1:0] bw);
    cen_n = 0; adv_ld = 1; addr = ADDR_W'(a); bw_n = bw;
  endtask

  task automatic desel();
    load(0, 0, 0, 2'b11);
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d, input logic [1:0] bw);
    load(1, 1, a, bw); step();
    dq_in = d; desel(); step();
  endtask

  task automatic read_check(input string tag, input int a, input logic [DW-1:0] exp);
    desel(); step();
    load(1, 0, a, 2'b11); step();
    load(1, 0, a, 2'b11); step();
    check({tag, " oe"}, 32'(dq_oe), 32'd1);
    check({tag, " data"}, 32'(dq_out), 32'(exp));
    desel(); step();
  endtask

  task automatic t_reset();
    check("R10 reset dq_oe", 32'(dq_oe), 32'd0);
  endtask

  task automatic t_write_read();
    load(1, 1, 5, 2'b00); step();
    check("R6 write data phase floats", 32'(dq_oe), 32'd0);
    dq_in = 18'h2A5C3;
    load(1, 0, 5, 2'b11); step();
    check("R3 R5 read after write oe", 32'(dq_oe), 32'd1);
    check("R3 R5 read after write data", 32'(dq_out), 32'h2A5C3);
    oe_n = 1; #1;
    check("R5 oe_n high floats", 32'(dq_oe), 32'd0);
    oe_n = 0; #1;
    check("R5 oe_n low drives", 32'(dq_oe), 32'd1);
    desel(); step();
    check("R1 deselected floats", 32'(dq_oe), 32'd0);
  endtask

  task automatic t_first_quiet();
    desel(); step();
    load(1, 0, 5, 2'b11); step();
    check("R7 first phase after deselect", 32'(dq_oe), 32'd0);
    load(1, 0, 5, 2'b11); step();
    check("R7 continued read drives", 32'(dq_oe), 32'd1);
    check("R7 continued read data", 32'(dq_out), 32'h2A5C3);
    desel(); step();
  endtask

  task automatic t_bytemask();
    write_word(7, 18'h3FFFF, 2'b00);
    write_word(7, 18'h00000, 2'b10);
    read_check("R4 lane0 only written", 7, 18'h3FE00);
    write_word(7, 18'h00000, 2'b01);
    read_check("R4 lane1 with parity written", 7, 18'h00000);
    write_word(8, 18'h00000, 2'b00);
    write_word(8, 18'h20100, 2'b00);
    write_word(8, 18'h00000, 2'b11);
    read_check("R4 parity bits both lanes", 8, 18'h20100);
  endtask

  task automatic t_read_no_write();
    load(1, 0, 7, 2'b00); step();
    dq_in = 18'h15555;
    load(1, 0, 7, 2'b00); step();
    desel(); step();
    read_check("R3 read leaves array", 7, 18'h00000);
  endtask

  task automatic t_stall();
    load(1, 1, 9, 2'b00); step();
    dq_in = 18'h0DEAD; cen_n = 1; addr = 6'd3; step();
    check("R2 stalled write phase floats", 32'(dq_oe), 32'd0);
    step();
    dq_in = 18'h1BEEF; load(1, 0, 9, 2'b11); step();
    check("R2 write held across stall", 32'(dq_out), 32'h1BEEF);
    cen_n = 1; addr = 6'd5; ce1_n = 1; step();
    check("R2 read held oe", 32'(dq_oe), 32'd1);
    check("R2 read held data", 32'(dq_out), 32'h1BEEF);
    desel(); step();
  endtask

  task automatic t_select();
    ce1_n = 0; ce2 = 0; ce3_n = 0; cen_n = 0; adv_ld = 0; we_n = 1; addr = 6'd5; step();
    check("R1 ce2 low deselects", 32'(dq_oe), 32'd0);
    ce2 = 1; ce3_n = 1; step();
    check("R1 ce3_n high deselects", 32'(dq_oe), 32'd0);
    load(0, 1, 5, 2'b00); step();
    dq_in = 18'h3FFFF; desel(); step();
    read_check("R1 unselected write ignored", 5, 18'h2A5C3);
  endtask

  task automatic t_advance();
    load(1, 1, 10, 2'b00); step();
    dq_in = 18'h0000A; ce1_n = 1; we_n = 1; advance(11, 2'b00); step();
    dq_in = 18'h0000B; advance(12, 2'b00); step();
    dq_in = 18'h0000C; desel(); step();
    step();
    load(1, 0, 10, 2'b11); step();
    load(1, 0, 10, 2'b11); step();
    check("R8 burst read 10", 32'(dq_out), 32'h0000A);
    ce1_n = 1; we_n = 0; advance(11, 2'b00); step();
    check("R8 advance ignores selects oe", 32'(dq_oe), 32'd1);
    check("R8 burst read 11", 32'(dq_out), 32'h0000B);
    advance(12, 2'b00); step();
    check("R8 burst read 12", 32'(dq_out), 32'h0000C);
    desel(); step();
    ce1_n = 0; we_n = 0; advance(10, 2'b00); step();
    dq_in = 18'h3FFFF; advance(10, 2'b00); step();
    check("R8 advance from deselect floats", 32'(dq_oe), 32'd0);
    read_check("R8 advance from deselect no write", 10, 18'h0000A);
  endtask

  task automatic t_sleep();
    load(1, 0, 9, 2'b11); step();
    load(1, 0, 9, 2'b11); step();
    sleep = 1; #1;
    check("R9 sleep floats immediately", 32'(dq_oe), 32'd0);
    load(1, 1, 9, 2'b00); step();
    dq_in = 18'h00001; step();
    check("R9 sleep still floats", 32'(dq_oe), 32'd0);
    sleep = 0; desel(); step();
    read_check("R9 contents kept through sleep", 9, 18'h1BEEF);
  endtask

  initial begin
    rst_n = 0; cen_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; we_n = 1; adv_ld = 0;
    oe_n = 0; sleep = 0; bw_n = '1; addr = '0; dq_in = '0;
    step(); step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_write_read();
    t_first_quiet();
    t_bytemask();
    t_read_no_write();
    t_stall();
    t_select();
    t_advance();
    t_sleep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule